// File: doc/BRIEF.md
# Scan Test Access Port with Instruction Decode

This block is the serial test port of a chip. A four-wire serial interface (test clock, mode select, data in, data out) walks a sixteen-state controller through capture, shift and update phases. Those phases read and load a 4-bit instruction register and one of three data paths:

- a single-bit pass-through stage;
- a 32-bit identification word;
- an external boundary cell chain, which is reached through a serial return input and three phase strobes.

The active instruction also sets two mode outputs for the functional pins. One puts every functional output into high impedance. The other drives the contents of the boundary cells onto those outputs.

The port has an optional active-low asynchronous reset. A generate switch, `HAS_TRST`, removes this reset. Without it, the controller still reaches its reset state after five test-clock edges with mode select held high.

Top module: `scan_tap`

## Requirements
- R1: An active-low `trstN` puts the controller into Test-Logic-Reset at once, without waiting for a clock edge. It also clears `outHighZ`, `outBoundary`, `bsrSelect` and `tdoEn`.
- R2: From any state, five rising `tck` edges with `tms` high reach Test-Logic-Reset. Four edges are not always enough. Entering that state makes the identification instruction (0010) the active instruction.
- R3: In Capture-IR the instruction shift stage loads 1101. Shift-IR presents this value on `tdo` least significant bit first, and `tdi` enters at the most significant bit.
- R4: The 4-bit instruction moves from the shift stage to the active instruction on the rising edge that enters Update-IR. In Exit1-IR the previous instruction still drives the outputs. After reset the active instruction is 0010.
- R5: With opcode 0010 active, Capture-DR loads the identification word. That word is {4'h2 version, 16-bit `PART_CODE`, 11'h033 maker code, 1'b1}, and it is shifted out LSB first.
- R6: Opcodes 1111, 0011, 1000 and every opcode with no defined function select the 1-bit pass-through stage. That stage captures 0, so `tdo` repeats `tdi` one shift later.
- R7: Opcode 0011 sets `outHighZ`. No other opcode sets it, and `outBoundary` is low while it is set.
- R8: Opcodes 0000 and 1000 set `outBoundary`. No other opcode sets it.
- R9: Opcodes 0000, 0001 and 1101 assert `bsrSelect`. With these opcodes only, `bsrCapture`, `bsrShift` and `bsrUpdate` follow the Capture-DR, Shift-DR and Update-DR states, and `bsrTdo` is routed to `tdo`.
- R10: `tms` and `tdi` are sampled on rising `tck`. `tdo` and `tdoEn` change only on falling `tck`, and `tdoEn` is high only in Shift-DR and Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous controller reset, active low |
| tms | input | 1 | Mode select that steers the state machine |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdoEn | output | 1 | Output enable for tdo, high while shifting |
| bsrTdo | input | 1 | Serial return from the external boundary chain |
| bsrSelect | output | 1 | Active instruction uses the boundary chain |
| bsrCapture | output | 1 | Boundary chain capture phase |
| bsrShift | output | 1 | Boundary chain shift phase |
| bsrUpdate | output | 1 | Boundary chain update phase |
| outHighZ | output | 1 | Force functional outputs to high impedance |
| outBoundary | output | 1 | Drive boundary cell contents onto functional outputs |

## Verification
The bench loads each defined opcode and several undefined ones, both directed and drawn at random from a seeded generator. For each opcode it runs a data-register scan. The scan length and the returned pattern show which path was chosen: a 32-bit identification word, a one-bit pass-through that captures zero, or a modelled external chain that returns 8'hA5.

Each instruction load also reads back the captured instruction pattern. It checks the mode outputs in Exit1-IR and again in Update-IR, so an early or late instruction update is caught.

A walk that holds mode select high from Shift-DR checks the mode outputs after the fourth and fifth edge. An asynchronous reset asserted between clock edges separates a synchronous reset from a true asynchronous one.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
  } tapStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic capIr;
    logic shIr;
    logic enterUpdIr;
    logic capDr;
    logic shDr;
    logic updDr;
    logic enterReset;
    logic inShift;
  } tapStrobeT;

  localparam int INSTR_W = 4;

  localparam logic [INSTR_W-1:0] OP_EXTEST   = 4'b0000;
  localparam logic [INSTR_W-1:0] OP_SAMPLE   = 4'b0001;
  localparam logic [INSTR_W-1:0] OP_IDCODE   = 4'b0010;
  localparam logic [INSTR_W-1:0] OP_HIGHZ    = 4'b0011;
  localparam logic [INSTR_W-1:0] OP_CLAMP    = 4'b1000;
  localparam logic [INSTR_W-1:0] OP_VALIDATE = 4'b1101;
  localparam logic [INSTR_W-1:0] OP_BYPASS   = 4'b1111;

  localparam logic [INSTR_W-1:0] IR_CAPTURE_PAT = 4'b1101;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic      tck,
  input  logic      rstN,
  input  logic      tms,
  output tapStateT  tapState,
  output tapStrobeT strb
);

  tapStateT nxt;

  always_comb begin
    nxt = ST_RESET;
    case (tapState)
      ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nxt = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: nxt = tms ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   nxt = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   nxt = tms ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nxt = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: nxt = tms ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   nxt = tms ? ST_SEL_DR   : ST_IDLE;
      default:     nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) tapState <= ST_RESET;
    else       tapState <= nxt;
  end

  always_comb begin
    strb.capIr      = (tapState == ST_CAP_IR);
    strb.shIr       = (tapState == ST_SHIFT_IR);
    strb.enterUpdIr = (nxt == ST_UPD_IR);
    strb.capDr      = (tapState == ST_CAP_DR);
    strb.shDr       = (tapState == ST_SHIFT_DR);
    strb.updDr      = (tapState == ST_UPD_DR);
    strb.enterReset = (nxt == ST_RESET);
    strb.inShift    = (tapState == ST_SHIFT_DR) || (tapState == ST_SHIFT_IR);
  end

endmodule

// File: rtl/scan_tap_dp.sv
module scan_tap_dp
  import scan_tap_pkg::*;
#(
  parameter logic [3:0]  VERSION   = 4'h2,
  parameter logic [15:0] PART_CODE = 16'h1C5B,
  parameter logic [10:0] VENDOR    = 11'h033
) (
  input  logic               tck,
  input  logic               rstN,
  input  logic               tdi,
  input  logic               bsrTdo,
  input  tapStrobeT          strb,
  output logic [INSTR_W-1:0] curInstr,
  output logic               selBsr,
  output logic               outHighZ,
  output logic               outBoundary,
  output logic               tdo,
  output logic               tdoEn
);

  localparam int ID_W = $bits(VERSION) + $bits(PART_CODE) + $bits(VENDOR) + 1;
  localparam logic [ID_W-1:0] ID_WORD = {VERSION, PART_CODE, VENDOR, 1'b1};

  logic [INSTR_W-1:0] irSh;
  logic [ID_W-1:0]    idSh;
  logic               bypassBit;
  logic               selId;

  // opcode decode; undefined codes fall to the pass-through stage
  always_comb begin
    selId       = 1'b0;
    selBsr      = 1'b0;
    outHighZ    = 1'b0;
    outBoundary = 1'b0;
    case (curInstr)
      OP_EXTEST:   begin selBsr = 1'b1; outBoundary = 1'b1; end
      OP_SAMPLE:   selBsr = 1'b1;
      OP_VALIDATE: selBsr = 1'b1;
      OP_IDCODE:   selId = 1'b1;
      OP_HIGHZ:    outHighZ = 1'b1;
      OP_CLAMP:    outBoundary = 1'b1;
      default:     ;
    endcase
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)           irSh <= '0;
    else if (strb.capIr) irSh <= IR_CAPTURE_PAT;
    else if (strb.shIr)  irSh <= {tdi, irSh[INSTR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                curInstr <= OP_IDCODE;
    else if (strb.enterReset) curInstr <= OP_IDCODE;
    else if (strb.enterUpdIr) curInstr <= irSh;
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)           bypassBit <= 1'b0;
    else if (strb.capDr) bypassBit <= 1'b0;
    else if (strb.shDr)  bypassBit <= tdi;
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                    idSh <= '0;
    else if (strb.capDr && selId) idSh <= ID_WORD;
    else if (strb.shDr && selId)  idSh <= {tdi, idSh[ID_W-1:1]};
  end

  // output stage on the falling edge
  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strb.inShift;
      if (strb.shIr)      tdo <= irSh[0];
      else if (strb.shDr) tdo <= selBsr ? bsrTdo : (selId ? idSh[0] : bypassBit);
      else                tdo <= 1'b0;
    end
  end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter bit          HAS_TRST  = 1'b1,
  parameter logic [3:0]  VERSION   = 4'h2,
  parameter logic [15:0] PART_CODE = 16'h1C5B,
  parameter logic [10:0] VENDOR    = 11'h033
) (
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdoEn,
  input  logic bsrTdo,
  output logic bsrSelect,
  output logic bsrCapture,
  output logic bsrShift,
  output logic bsrUpdate,
  output logic outHighZ,
  output logic outBoundary
);

  logic               rstN;
  tapStateT           tapState;
  tapStrobeT          strb;
  logic [INSTR_W-1:0] curInstr;

  generate
    if (HAS_TRST) begin : g_trst
      assign rstN = trstN;
    end else begin : g_no_trst
      assign rstN = 1'b1;
    end
  endgenerate

  scan_tap_fsm u_fsm (
    .tck      (tck),
    .rstN     (rstN),
    .tms      (tms),
    .tapState (tapState),
    .strb     (strb)
  );

  scan_tap_dp #(
    .VERSION   (VERSION),
    .PART_CODE (PART_CODE),
    .VENDOR    (VENDOR)
  ) u_dp (
    .tck         (tck),
    .rstN        (rstN),
    .tdi         (tdi),
    .bsrTdo      (bsrTdo),
    .strb        (strb),
    .curInstr    (curInstr),
    .selBsr      (bsrSelect),
    .outHighZ    (outHighZ),
    .outBoundary (outBoundary),
    .tdo         (tdo),
    .tdoEn       (tdoEn)
  );

  assign bsrCapture = strb.capDr & bsrSelect;
  assign bsrShift   = strb.shDr  & bsrSelect;
  assign bsrUpdate  = strb.updDr & bsrSelect;

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic               tck,
  input logic               trstN,
  input logic               tms,
  input tapStateT           tapState,
  input logic [INSTR_W-1:0] curInstr,
  input logic               tdoEn,
  input logic               bsrSelect,
  input logic               bsrCapture,
  input logic               bsrShift,
  input logic               bsrUpdate,
  input logic               outHighZ,
  input logic               outBoundary
);

  logic [2:0] onesCnt;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                 onesCnt <= '0;
    else if (!tms)              onesCnt <= '0;
    else if (onesCnt != 3'd5)   onesCnt <= onesCnt + 3'd1;
  end

  p_five_ones_reset_r2: assert property (@(posedge tck) disable iff (!trstN)
    (onesCnt == 3'd5) |-> (tapState == ST_RESET));

  p_instr_change_r4: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(curInstr) |-> (tapState == ST_UPD_IR || tapState == ST_RESET));

  p_highz_excl_r7: assert property (@(posedge tck) disable iff (!trstN)
    outHighZ |-> (!outBoundary && !bsrSelect));

  p_chain_strobe_r9: assert property (@(posedge tck) disable iff (!trstN)
    (bsrCapture || bsrShift || bsrUpdate) |-> (bsrSelect && $onehot0({bsrCapture, bsrShift, bsrUpdate})));

  p_tdo_en_shift_r10: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn == (tapState == ST_SHIFT_DR || tapState == ST_SHIFT_IR));

  p_reset_idcode_r1: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == ST_RESET) |-> (curInstr == OP_IDCODE && !outHighZ && !outBoundary));

endmodule

bind scan_tap scan_tap_chk u_chk (
  .tck         (tck),
  .trstN       (trstN),
  .tms         (tms),
  .tapState    (tapState),
  .curInstr    (curInstr),
  .tdoEn       (tdoEn),
  .bsrSelect   (bsrSelect),
  .bsrCapture  (bsrCapture),
  .bsrShift    (bsrShift),
  .bsrUpdate   (bsrUpdate),
  .outHighZ    (outHighZ),
  .outBoundary (outBoundary)
);

// File: tb/sim_scan_tap.sv
`timescale 1ns/1ps
module sim_scan_tap;

  localparam logic [15:0] PART = 16'h6E21;
  localparam logic [31:0] ID_EXP = {4'h2, PART, 11'h033, 1'b1};

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bsrTdo;
  logic tdo, tdoEn, bsrSelect, bsrCapture, bsrShift, bsrUpdate, outHighZ, outBoundary;
  logic [7:0] chainReg;
  logic [3:0] curOp;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #4 tck = ~tck;

  scan_tap #(.PART_CODE(PART)) u0 (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .bsrTdo(bsrTdo), .bsrSelect(bsrSelect), .bsrCapture(bsrCapture),
    .bsrShift(bsrShift), .bsrUpdate(bsrUpdate),
    .outHighZ(outHighZ), .outBoundary(outBoundary)
  );

  // model of the external boundary chain
  always @(posedge tck) begin
    if (bsrCapture)    chainReg <= 8'hA5;
    else if (bsrShift) chainReg <= {tdi, chainReg[7:1]};
  end
  assign bsrTdo = chainReg[0];

  function automatic bit expHz(input logic [3:0] op);  return op == 4'b0011; endfunction
  function automatic bit expBd(input logic [3:0] op);  return op == 4'b0000 || op == 4'b1000; endfunction
  function automatic bit expBsr(input logic [3:0] op); return op == 4'b0000 || op == 4'b0001 || op == 4'b1101; endfunction
  function automatic bit expId(input logic [3:0] op);  return op == 4'b0010; endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // one test clock: drive, rising edge (tdo must hold), falling edge
  task automatic tick(input logic m, input logic d);
    logic pre;
    tms = m;
    tdi = d;
    pre = tdo;
    @(posedge tck);
    #1;
    check("R10 tdo held at rising edge", {31'd0, tdo}, {31'd0, pre});
    @(negedge tck);
    #1;
  endtask

  task automatic checkModes(input string tag, input logic [3:0] op);
    check({tag, " R7 outHighZ"}, {31'd0, outHighZ}, {31'd0, expHz(op)});
    check({tag, " R8 outBoundary"}, {31'd0, outBoundary}, {31'd0, expBd(op)});
    check({tag, " R9 bsrSelect"}, {31'd0, bsrSelect}, {31'd0, expBsr(op)});
  endtask

  // from Run-Test/Idle, load an instruction and return to Run-Test/Idle
  task automatic loadIr(input logic [3:0] op);
    logic [3:0] cap;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    check("R10 tdoEn in Shift-IR", {31'd0, tdoEn}, 32'd1);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      tick(i == 3, op[i]);
    end
    check("R3 capture pattern", {28'd0, cap}, 32'hD);
    check("R10 tdoEn low in Exit1-IR", {31'd0, tdoEn}, 32'd0);
    checkModes("R4 old instr in Exit1-IR", curOp);
    tick(1, 0);
    checkModes("R4 new instr in Update-IR", op);
    curOp = op;
    tick(0, 0);
  endtask

  // data register scan of n bits from Run-Test/Idle back to Run-Test/Idle
  task automatic scanDr(input int n, input logic [31:0] din, output logic [31:0] dout,
                        output logic sCap, output logic sSh, output logic sUpd);
    dout = '0;
    tick(1, 0); tick(0, 0);
    sCap = bsrCapture;
    tick(0, 0);
    sSh = bsrShift;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0);
    sUpd = bsrUpdate;
    tick(0, 0);
  endtask

  task automatic checkDr(input logic [31:0] din);
    logic [31:0] dout;
    logic c, s, u;
    if (expId(curOp)) begin
      scanDr(32, din, dout, c, s, u);
      check("R5 identification word", dout, ID_EXP);
    end else if (expBsr(curOp)) begin
      scanDr(8, din, dout, c, s, u);
      check("R9 chain data on tdo", dout, 32'hA5);
    end else begin
      scanDr(8, din, dout, c, s, u);
      check("R6 pass-through", dout, {24'd0, din[6:0], 1'b0});
    end
    check("R9 strobes", {29'd0, c, s, u}, expBsr(curOp) ? 32'd7 : 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [3:0] dirOps [10];
    logic [31:0] seed;
    curOp = 4'b0010;
    dirOps = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b1000, 4'b1101, 4'b1111, 4'b0100, 4'b0111, 4'b1110};
    seed = $urandom(32'd2024);
    @(negedge tck); #1;
    check("R1 tdoEn in reset", {31'd0, tdoEn}, 32'd0);
    checkModes("R1 reset", 4'b0010);
    trstN = 1'b1;
    tick(0, 0);
    checkDr(32'h1234_5678);              // R4 reset instruction is identification

    foreach (dirOps[k]) begin
      loadIr(dirOps[k]);
      checkDr($urandom);
    end

    for (int k = 0; k < 30; k++) begin
      loadIr(4'($urandom % 16));
      checkDr($urandom);
    end

    // R2: five rising edges with tms high from Shift-DR
    loadIr(4'b0011);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int k = 0; k < 4; k++) tick(1, 0);
    check("R2 four ones not yet reset", {31'd0, outHighZ}, 32'd1);
    tick(1, 0);
    check("R2 five ones reach reset", {31'd0, outHighZ}, 32'd0);
    curOp = 4'b0010;
    tick(0, 0);
    checkDr(32'hCAFE_0001);

    // R1: asynchronous reset between clock edges
    loadIr(4'b1000);
    #2 trstN = 1'b0;
    #1;
    check("R1 async clears outBoundary", {31'd0, outBoundary}, 32'd0);
    check("R1 async clears bsrSelect", {31'd0, bsrSelect}, 32'd0);
    @(negedge tck); #1;
    trstN = 1'b1;
    curOp = 4'b0010;
    tick(0, 0);
    checkDr(32'h0);

    finishRun();
  end

endmodule